// File: doc/BRIEF.md
# Rolling Shutter Row Pointer Sequencer

This block steers the vertical scan of a rolling-shutter pixel array. Two row
pointers sweep the array one behind the other. The leading pointer selects rows
for reset. The trailing pointer selects rows for readout. The distance between
them is the exposure, counted in row clocks. A frame-start pulse restarts the
sweep. Each row-clock pulse moves the pointers on by one row. Two counters
decide when the trailing pointer enters the array and when the frame ends.

A dual-sample mode makes both counters advance on every second row clock only.
In that mode the end-of-frame pulse waits one extra row clock, so that the row
under the trailing pointer is read first. A fast-reset mode makes the trailing
outputs copy the leading ones, so both pointers scan together. All inputs are
single-cycle control strobes or static settings, and all outputs are plain
control signals. No data stream passes through the block, so it has no
valid/ready handshake and no back-pressure.

Top module: `row_ptr_seq`

## Requirements
- R1: A cycle with `frame_start` high gives a one-cycle `left_sync` pulse in the next cycle. In that same cycle `left_ptr` equals `start_row`, both counters are cleared and the frame is running. This also holds during a running frame, which then restarts from the beginning.
- R2: Each `row_clk` pulse in a running frame moves `left_ptr` on by one in the next cycle. When no frame is running, `row_clk` is ignored and both pointers hold.
- R3: The integration counter counts row clocks. When it becomes equal to `int_time`, `right_sync` pulses in the next cycle and `right_ptr` is loaded with `start_row`. If `int_time` is 0, this happens together with `left_sync`.
- R4: After its sync, `right_ptr` moves on by one for every later row clock of the frame. Before its sync, `right_ptr` holds `start_row`.
- R5: In normal mode, `eof` pulses in the cycle after row clock number `line_count` of the frame, and the frame stops running (`line_count` must be at least 1).
- R6: When `dual_mode` is 1, the integration and line counters advance only on the 2nd, 4th, 6th and later even row clocks of the frame. `right_sync` therefore follows row clock 2*`int_time`.
- R7: When `dual_mode` is 1, `eof` follows row clock 2*`line_count`+1. That extra row clock reads the trailing pointer's row.
- R8: While `fast_reset` is 1, `right_ptr` equals `left_ptr` and `right_sync` equals `left_sync` in the same cycle.
- R9: A pointer at row ROWS-1 that advances goes to row 0.
- R10: `left_sync` (unless `frame_start` is held), `right_sync` and `eof` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that starts a frame |
| row_clk | input | 1 | One-cycle strobe that steps one row |
| dual_mode | input | 1 | 1 = counters advance on every second row clock |
| fast_reset | input | 1 | 1 = trailing outputs copy the leading outputs |
| start_row | input | ROW_W | Row loaded into a pointer at its sync |
| int_time | input | CNT_W | Exposure length in counted row clocks |
| line_count | input | CNT_W | Frame length in counted row clocks |
| left_ptr | output | ROW_W | Leading (reset) row address |
| right_ptr | output | ROW_W | Trailing (readout) row address |
| left_sync | output | 1 | Leading pointer load pulse |
| right_sync | output | 1 | Trailing pointer load pulse |
| eof | output | 1 | End-of-frame pulse |

## Verification
The bench runs a normal frame with idle gaps between row clocks and continues past `eof`. This separates correct counting from counting on every clock, and shows that row clocks are ignored once the frame ends. A dual-sample frame with back-to-back row clocks checks whether the halving counts even or odd row clocks, and whether the extra row clock before `eof` is present. Further runs use a zero exposure, a start row near the top of the array (wrap-around), fast reset, and a restart in the middle of a frame. Each of these runs isolates one path of the design.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } rps_state_e;
endpackage

// File: rtl/rps_row_ptr.sv
module rps_row_ptr #(
  parameter int ROWS = 3008,
  localparam int W = $clog2(ROWS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  output logic [W-1:0] ptr
);
  localparam logic [W-1:0] LAST = W'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/rps_match_cnt.sv
module rps_match_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] target,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic [W-1:0] nxt;

  assign nxt = cnt + 1'b1;
  assign hit = inc && (nxt == target);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= nxt;
  end
endmodule

// File: rtl/row_ptr_seq.sv
module row_ptr_seq #(
  parameter int ROWS  = 3008,
  parameter int CNT_W = 12,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             row_clk,
  input  logic             dual_mode,
  input  logic             fast_reset,
  input  logic [ROW_W-1:0] start_row,
  input  logic [CNT_W-1:0] int_time,
  input  logic [CNT_W-1:0] line_count,
  output logic [ROW_W-1:0] left_ptr,
  output logic [ROW_W-1:0] right_ptr,
  output logic             left_sync,
  output logic             right_sync,
  output logic             eof
);
  import rps_pkg::*;

  rps_state_e       state;
  logic             half;
  logic             r_loaded;
  logic             lsync_q, rsync_q, eof_q;
  logic [ROW_W-1:0] rptr_q;
  logic             rc_live, step, cnt_inc, int_inc;
  logic             int_hit, line_hit, zero_int;

  assign zero_int = (int_time == '0);
  assign rc_live  = row_clk && (state != ST_IDLE) && !frame_start;
  assign step     = rc_live && (!dual_mode || half);
  assign cnt_inc  = step && (state == ST_RUN);
  assign int_inc  = cnt_inc && !r_loaded;

  rps_match_cnt #(.W(CNT_W)) u_int_cnt (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .inc(int_inc),
    .target(int_time), .hit(int_hit)
  );

  rps_match_cnt #(.W(CNT_W)) u_line_cnt (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .inc(cnt_inc),
    .target(line_count), .hit(line_hit)
  );

  rps_row_ptr #(.ROWS(ROWS)) u_left (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_val(start_row),
    .adv(rc_live), .ptr(left_ptr)
  );

  rps_row_ptr #(.ROWS(ROWS)) u_right (
    .clk(clk), .rst_n(rst_n), .load(frame_start || int_hit),
    .load_val(start_row), .adv(rc_live && r_loaded), .ptr(rptr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half     <= 1'b0;
      r_loaded <= 1'b0;
      lsync_q  <= 1'b0;
      rsync_q  <= 1'b0;
      eof_q    <= 1'b0;
    end else begin
      lsync_q <= frame_start;
      rsync_q <= (frame_start && zero_int) || int_hit;
      eof_q   <= 1'b0;
      if (frame_start) begin
        state    <= ST_RUN;
        half     <= 1'b0;
        r_loaded <= zero_int;
      end else if (rc_live) begin
        half <= !half;
        if (int_hit) r_loaded <= 1'b1;
        if (state == ST_TAIL) begin
          eof_q <= 1'b1;
          state <= ST_IDLE;
        end else if (line_hit) begin
          if (dual_mode) begin
            state <= ST_TAIL;
          end else begin
            eof_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
      end
    end
  end

  assign left_sync  = lsync_q;
  assign eof        = eof_q;
  assign right_ptr  = fast_reset ? left_ptr : rptr_q;
  assign right_sync = fast_reset ? lsync_q  : rsync_q;
endmodule

// File: rtl/rps_chk.sv
module rps_chk #(
  parameter int ROWS = 3008,
  localparam int W = $clog2(ROWS)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_start,
  input logic         fast_reset,
  input logic [W-1:0] start_row,
  input logic [W-1:0] left_ptr,
  input logic [W-1:0] right_ptr,
  input logic         left_sync,
  input logic         right_sync,
  input logic         eof
);
  localparam logic [W-1:0] LAST = W'(ROWS - 1);

  AST_LSYNC_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> left_sync); // R1

  AST_LPTR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (left_ptr == $past(start_row))); // R1

  AST_LPTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start) && (left_ptr != $past(left_ptr)) && ($past(left_ptr) != LAST))
      |-> (left_ptr == $past(left_ptr) + 1'b1)); // R2

  AST_LPTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start) && (left_ptr != $past(left_ptr)) && ($past(left_ptr) == LAST))
      |-> (left_ptr == '0)); // R9

  AST_RPTR_LOAD_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (right_sync && !fast_reset) |-> (right_ptr == $past(start_row))); // R3

  AST_IDLE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !frame_start) |=> $stable(left_ptr)); // R5

  AST_EOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof); // R10

  AST_LSYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (left_sync && !frame_start) |=> !left_sync); // R10
endmodule

bind row_ptr_seq rps_chk #(.ROWS(ROWS)) u_rps_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fast_reset(fast_reset),
  .start_row(start_row), .left_ptr(left_ptr), .right_ptr(right_ptr),
  .left_sync(left_sync), .right_sync(right_sync), .eof(eof)
);

// File: tb/row_ptr_seq_test.sv
`timescale 1ns/1ps
module row_ptr_seq_test;
  localparam int ROWS = 20;
  localparam int CW   = 8;
  localparam int RW   = 5;

  typedef struct packed {
    logic [RW-1:0] lp;
    logic [RW-1:0] rp;
    logic ls, rs, e;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, row_clk = 1'b0, dual_mode = 1'b0, fast_reset = 1'b0;
  logic [RW-1:0] start_row = '0;
  logic [CW-1:0] int_time = '0, line_count = '0;
  logic [RW-1:0] left_ptr, right_ptr;
  logic left_sync, right_sync, eof;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  string phase = "reset";
  exp_t q[$];

  int m_st = 0, m_half = 0, m_ic = 0, m_lc = 0, m_lp = 0, m_rp = 0, m_rl = 0;

  always #4 clk = ~clk;

  row_ptr_seq #(.ROWS(ROWS), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_clk(row_clk),
    .dual_mode(dual_mode), .fast_reset(fast_reset), .start_row(start_row),
    .int_time(int_time), .line_count(line_count), .left_ptr(left_ptr),
    .right_ptr(right_ptr), .left_sync(left_sync), .right_sync(right_sync), .eof(eof)
  );

  function automatic int nxt(int p);
    return (p == ROWS - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  // Driver: applies one cycle of strobes and pushes the expected outputs.
  task automatic cyc(input logic fs, input logic rc);
    exp_t x;
    int ls, rs, e, step;
    @(negedge clk);
    frame_start = fs;
    row_clk = rc;
    ls = 0; rs = 0; e = 0;
    if (fs) begin
      m_st = 1; m_half = 0; m_ic = 0; m_lc = 0;
      m_lp = int'(start_row); m_rp = int'(start_row);
      m_rl = (int_time == 0) ? 1 : 0;
      ls = 1; rs = m_rl;
    end else if (rc && m_st != 0) begin
      step = (!dual_mode || m_half != 0) ? 1 : 0;
      m_half = 1 - m_half;
      m_lp = nxt(m_lp);
      if (m_rl != 0) m_rp = nxt(m_rp);
      if (m_st == 2) begin
        e = 1; m_st = 0;
      end else if (step != 0) begin
        if (m_rl == 0) begin
          m_ic++;
          if (m_ic == int'(int_time)) begin
            m_rl = 1; m_rp = int'(start_row); rs = 1;
          end
        end
        m_lc++;
        if (m_lc == int'(line_count)) begin
          if (dual_mode) m_st = 2;
          else begin e = 1; m_st = 0; end
        end
      end
    end
    x.lp = RW'(m_lp);
    x.rp = fast_reset ? RW'(m_lp) : RW'(m_rp);
    x.ls = ls[0];
    x.rs = fast_reset ? ls[0] : rs[0];
    x.e  = e[0];
    q.push_back(x);
  endtask

  // Monitor: compares outputs shortly after each rising edge.
  always @(posedge clk) begin
    exp_t x;
    #2;
    if (q.size() > 0) begin
      x = q.pop_front();
      chk("R1 left_sync",  int'(left_sync),  int'(x.ls));
      chk("R2 left_ptr",   int'(left_ptr),   int'(x.lp));
      chk("R3 right_sync", int'(right_sync), int'(x.rs));
      chk("R4 right_ptr",  int'(right_ptr),  int'(x.rp));
      chk("R5 eof",        int'(eof),        int'(x.e));
    end
  end

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic rows_gap(int n);
    repeat (n) begin cyc(0, 1); cyc(0, 0); end
  endtask

  task automatic rows_b2b(int n);
    repeat (n) cyc(0, 1);
    cyc(0, 0);
  endtask

  task automatic setup(string ph, logic dm, logic fr, int sr, int it, int lc);
    drain();
    phase = ph; dual_mode = dm; fast_reset = fr;
    start_row = RW'(sr); int_time = CW'(it); line_count = CW'(lc);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog [%s] actual=hung expected=done", phase);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: everything low / zero.
    chk("R1 reset left_sync", int'(left_sync), 0);
    chk("R2 reset left_ptr",  int'(left_ptr),  0);
    chk("R4 reset right_ptr", int'(right_ptr), 0);
    chk("R5 reset eof",       int'(eof),       0);

    // R2: row clocks with no frame running are ignored.
    setup("R2 idle", 0, 0, 3, 4, 6);
    rows_gap(3);

    // R1 R3 R4 R5 R10: normal frame with gaps, then row clocks after eof.
    setup("R5 normal", 0, 0, 3, 4, 6);
    cyc(1, 0);
    rows_gap(9);

    // R6 R7: dual-sample frame, back-to-back row clocks.
    setup("R6 R7 dual", 1, 0, 5, 2, 3);
    cyc(1, 0);
    rows_b2b(10);

    // R3: zero exposure loads the trailing pointer with the leading one.
    setup("R3 zero int", 0, 0, 7, 0, 4);
    cyc(1, 0);
    rows_gap(6);

    // R9: pointers wrap past the last row.
    setup("R9 wrap", 0, 0, 17, 2, 8);
    cyc(1, 0);
    rows_b2b(9);

    // R8: fast reset makes both pointers scan together.
    setup("R8 fast", 0, 1, 4, 3, 5);
    cyc(1, 0);
    rows_gap(7);

    // R1: restart in the middle of a running frame.
    setup("R1 restart", 0, 0, 2, 3, 5);
    cyc(1, 0);
    rows_gap(3);
    cyc(1, 1);
    rows_gap(7);

    // R7: dual mode with gaps and odd-length exposure.
    setup("R7 dual gap", 1, 0, 0, 3, 4);
    cyc(1, 0);
    rows_gap(11);

    drain();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule